// File: doc/BRIEF.md
# Flash Embedded Command Controller

This block controls a small sector-organised flash array from a plain asynchronous-style host bus. The host drives active-low chip-enable, write-enable and output-enable strobes, which are sampled on the system clock. A write cycle is taken on the clock edge that first sees `we_n` high after it was low while `ce_n` is low. A read strobe is the clock edge that first sees `oe_n` low after it was high while `ce_n` is low. Command writes pass through an unlock sequence. The controller then runs an internal program or sector-erase algorithm and times every pulse with a counter. While it works, progress can be read back on the data bus and on a ready/busy pin.

The array has `2**ARR_W` byte words split into `2**SEC_W` equal sectors. The sector number is the top `SEC_W` bits of the word address. The unlock cycles are 0xAA at address 0x555, then 0x55 at 0x2AA, compared on the low 11 address bits. A program follows the unlock with 0xA0 at 0x555 and then the data at the target address. An erase follows the unlock with 0x80 at 0x555, a second unlock, and then 0x30 at any address inside the sector. With no sequence in progress, a single write of 0xB0 suspends an erase, 0x30 resumes it and 0xF0 leaves the error state. Per-sector write protection and a low-supply write inhibit are plain inputs.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset `ry_by` is 1 and every array word reads 0xFF.
- R2: A program sequence leaves the target word equal to its old value AND the data. `ry_by` is 0 from the cycle after the final write cycle, and returns to 1 exactly `PROG_PULSE` cycles later.
- R3: While an operation runs (`ry_by`=0), reads at any address return status. Bit 7 is the complement of data bit 7 for a program and 0 for an erase. Bit 6 inverts on every read strobe. Bit 5 is 0 and bits 4..0 are 0. Once the operation ends, reads return array data again.
- R4: An erase first drives every nonzero word of the sector to 0x00, one `PROG_PULSE` pulse per word. It then waits `ERASE_PULSE` cycles and leaves every word of the sector at 0xFF. Words of all other sectors are unchanged.
- R5: With `wp_sec[s]`=1, program and erase sequences aimed at sector s change nothing, and `ry_by` stays 1.
- R6: 0xB0 written during an erase sets `ry_by` to 1 in the next cycle. Reads then return array contents, including the partially pre-programmed words of the sector being erased. 0x30 resumes the erase, `ry_by` drops in the next cycle, and the erase completes.
- R7: While an erase is suspended, a program sequence to another sector runs and ends back in the suspended state. A program sequence aimed at the sector being erased changes nothing, and `ry_by` stays 1.
- R8: A cycle that does not match the expected next step of a sequence returns the decoder to read mode, so the remaining cycles of that sequence cause no operation.
- R9: Write cycles taken while `vlow`=1 are ignored entirely.
- R10: A program that needs a 0 bit set back to 1 gives `MAX_RETRY` pulses and then enters an error state. In that state `ry_by` stays 0, reads show bit 7 as the complement of data bit 7 and bit 5 as 1, bit 6 keeps toggling, and the word holds old AND data. Writing 0xF0 returns the controller to read mode with `ry_by`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low; a write is taken on its rising edge |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; low 11 bits for unlock compare, low ARR_W bits for the array |
| din | input | 8 | Write data / command byte |
| vlow | input | 1 | Low-supply detect; blocks every write cycle while high |
| wp_sec | input | 2**SEC_W | Per-sector write protection, one bit per sector |
| dout | output | 8 | Read data or status byte while ce_n and oe_n are low, else 0 |
| ry_by | output | 1 | 1 when ready, 0 while an algorithm runs or after a program error |

## Verification
The hardest state to reach is a suspended erase that stopped partway through pre-programming, with a second program running inside the suspension. The bench starts an erase on an erased sector, where every word is nonzero and so costs one full pulse. It counts a fixed number of cycles so that exactly two words are already cleared, then writes the suspend byte. The sector is read back to show the cleared words next to untouched ones. A program is run in a neighbouring sector and another is tried on the erasing sector. The erase is then resumed and must still finish to all ones.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    localparam int FCC_DW  = 8;
    localparam int UNLK_AW = 11;

    localparam logic [UNLK_AW-1:0] ADR_A = 11'h555;
    localparam logic [UNLK_AW-1:0] ADR_B = 11'h2AA;

    localparam logic [FCC_DW-1:0] K_AA   = 8'hAA;
    localparam logic [FCC_DW-1:0] K_55   = 8'h55;
    localparam logic [FCC_DW-1:0] K_PRG  = 8'hA0;
    localparam logic [FCC_DW-1:0] K_ERS  = 8'h80;
    localparam logic [FCC_DW-1:0] K_CONF = 8'h30;
    localparam logic [FCC_DW-1:0] K_SUSP = 8'hB0;
    localparam logic [FCC_DW-1:0] K_RST  = 8'hF0;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_PROG, CMD_ERASE, CMD_SUSP, CMD_RESUME, CMD_RESET
    } cmd_e;

    typedef enum logic [2:0] {
        D_IDLE, D_U1, D_U2, D_PDATA, D_E80, D_EU1, D_EU2
    } dec_e;

    typedef enum logic [2:0] {
        E_IDLE, E_PROG, E_PRE, E_ERASE, E_FILL, E_SUSP, E_ERR
    } eng_e;

    typedef struct packed {
        logic busy;
        logic err;
        logic poll;
    } stat_t;

    function automatic logic first_unlock(logic [UNLK_AW-1:0] a, logic [FCC_DW-1:0] d);
        return (a == ADR_A) && (d == K_AA);
    endfunction

    function automatic logic second_unlock(logic [UNLK_AW-1:0] a, logic [FCC_DW-1:0] d);
        return (a == ADR_B) && (d == K_55);
    endfunction

    function automatic logic eng_busy(eng_e s);
        return (s == E_PROG) || (s == E_PRE) || (s == E_ERASE) ||
               (s == E_FILL) || (s == E_ERR);
    endfunction

endpackage

// File: rtl/fcc_cmd_decode.sv
module fcc_cmd_decode
    import fcc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_evt,
    input  logic [UNLK_AW-1:0]   wa,
    input  logic [FCC_DW-1:0]    wd,
    output cmd_e                 cmd_kind
);

    dec_e st, st_nx;

    always_comb begin
        st_nx    = st;
        cmd_kind = CMD_NONE;
        if (wr_evt) begin
            case (st)
                D_IDLE: begin
                    if (first_unlock(wa, wd))  st_nx = D_U1;
                    else if (wd == K_RST)      cmd_kind = CMD_RESET;
                    else if (wd == K_SUSP)     cmd_kind = CMD_SUSP;
                    else if (wd == K_CONF)     cmd_kind = CMD_RESUME;
                end
                D_U1:  st_nx = second_unlock(wa, wd) ? D_U2 : D_IDLE;
                D_U2: begin
                    if (wa == ADR_A && wd == K_PRG)      st_nx = D_PDATA;
                    else if (wa == ADR_A && wd == K_ERS) st_nx = D_E80;
                    else                                 st_nx = D_IDLE;
                end
                D_PDATA: begin
                    cmd_kind = CMD_PROG;
                    st_nx    = D_IDLE;
                end
                D_E80: st_nx = first_unlock(wa, wd) ? D_EU1 : D_IDLE;
                D_EU1: st_nx = second_unlock(wa, wd) ? D_EU2 : D_IDLE;
                D_EU2: begin
                    if (wd == K_CONF) cmd_kind = CMD_ERASE;
                    st_nx = D_IDLE;
                end
                default: st_nx = D_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= D_IDLE;
        else     st <= st_nx;
    end

endmodule

// File: rtl/fcc_array.sv
module fcc_array
    import fcc_pkg::*;
#(
    parameter int ARR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ARR_W-1:0]  ra_host,
    output logic [FCC_DW-1:0] rd_host,
    input  logic [ARR_W-1:0]  ra_eng,
    output logic [FCC_DW-1:0] rd_eng,
    input  logic              we,
    input  logic [ARR_W-1:0]  wa,
    input  logic [FCC_DW-1:0] wd
);

    localparam int WORDS = 1 << ARR_W;

    logic [FCC_DW-1:0] cells [WORDS];

    assign rd_host = cells[ra_host];
    assign rd_eng  = cells[ra_eng];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) cells[i] <= '1;
        end else if (we) begin
            cells[wa] <= wd;
        end
    end

endmodule

// File: rtl/fcc_algo.sv
module fcc_algo
    import fcc_pkg::*;
#(
    parameter int ARR_W       = 6,
    parameter int SEC_W       = 2,
    parameter int PROG_PULSE  = 8,
    parameter int ERASE_PULSE = 64,
    parameter int MAX_RETRY   = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  cmd_e                   cmd_kind,
    input  logic [ARR_W-1:0]       cmd_addr,
    input  logic [FCC_DW-1:0]      cmd_data,
    input  logic [(1<<SEC_W)-1:0]  wp_sec,
    input  logic [FCC_DW-1:0]      rd_word,
    output eng_e                   st,
    output stat_t                  stat,
    output logic [ARR_W-1:0]       eng_raddr,
    output logic                   wr_en,
    output logic [ARR_W-1:0]       wr_addr,
    output logic [FCC_DW-1:0]      wr_data
);

    localparam int IDX_W    = ARR_W - SEC_W;
    localparam int LAST_IDX = (1 << IDX_W) - 1;
    localparam int CNT_MAX  = (PROG_PULSE > ERASE_PULSE) ? PROG_PULSE : ERASE_PULSE;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int RTY_W    = $clog2(MAX_RETRY + 1);

    logic [ARR_W-1:0]  p_addr;
    logic [FCC_DW-1:0] p_data;
    logic [CNT_W-1:0]  cnt;
    logic [RTY_W-1:0]  retry;
    logic              from_susp;
    logic [SEC_W-1:0]  e_sec;
    logic [IDX_W-1:0]  e_idx;
    eng_e              res_st;

    logic [SEC_W-1:0]  c_sec;
    logic              c_open;
    logic              prog_end, erase_end, idx_last, verify_ok;
    logic [ARR_W-1:0]  erase_addr;

    assign c_sec      = cmd_addr[ARR_W-1 -: SEC_W];
    assign c_open     = !wp_sec[c_sec];
    assign prog_end   = (cnt == CNT_W'(PROG_PULSE - 1));
    assign erase_end  = (cnt == CNT_W'(ERASE_PULSE - 1));
    assign idx_last   = (e_idx == IDX_W'(LAST_IDX));
    assign verify_ok  = ((rd_word & p_data) == p_data);
    assign erase_addr = {e_sec, e_idx};

    assign stat.busy = eng_busy(st);
    assign stat.err  = (st == E_ERR);
    assign stat.poll = ((st == E_PROG) || (st == E_ERR)) ? ~p_data[FCC_DW-1] : 1'b0;

    always_comb begin
        eng_raddr = (st == E_PROG) ? p_addr : erase_addr;
        wr_en     = 1'b0;
        wr_addr   = erase_addr;
        wr_data   = '0;
        case (st)
            E_PROG: if (prog_end) begin
                wr_en   = 1'b1;
                wr_addr = p_addr;
                wr_data = rd_word & p_data;
            end
            E_PRE: if (prog_end && rd_word != '0) begin
                wr_en   = 1'b1;
                wr_data = '0;
            end
            E_FILL: begin
                wr_en   = 1'b1;
                wr_data = '1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= E_IDLE;
            p_addr    <= '0;
            p_data    <= '0;
            cnt       <= '0;
            retry     <= '0;
            from_susp <= 1'b0;
            e_sec     <= '0;
            e_idx     <= '0;
            res_st    <= E_PRE;
        end else begin
            case (st)
                E_IDLE: begin
                    if (cmd_kind == CMD_PROG && c_open) begin
                        p_addr    <= cmd_addr;
                        p_data    <= cmd_data;
                        cnt       <= '0;
                        retry     <= '0;
                        from_susp <= 1'b0;
                        st        <= E_PROG;
                    end else if (cmd_kind == CMD_ERASE && c_open) begin
                        e_sec <= c_sec;
                        e_idx <= '0;
                        cnt   <= '0;
                        st    <= E_PRE;
                    end
                end
                E_PROG: begin
                    if (prog_end) begin
                        cnt <= '0;
                        if (verify_ok)
                            st <= from_susp ? E_SUSP : E_IDLE;
                        else if (retry == RTY_W'(MAX_RETRY - 1))
                            st <= E_ERR;
                        else
                            retry <= retry + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                E_PRE: begin
                    if (cmd_kind == CMD_SUSP) begin
                        res_st <= E_PRE;
                        st     <= E_SUSP;
                    end else if (rd_word == '0 || prog_end) begin
                        cnt <= '0;
                        if (idx_last) st <= E_ERASE;
                        else          e_idx <= e_idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                E_ERASE: begin
                    if (cmd_kind == CMD_SUSP) begin
                        res_st <= E_ERASE;
                        st     <= E_SUSP;
                    end else if (erase_end) begin
                        cnt   <= '0;
                        e_idx <= '0;
                        st    <= E_FILL;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                E_FILL: begin
                    if (cmd_kind == CMD_SUSP) begin
                        res_st <= E_FILL;
                        st     <= E_SUSP;
                    end else if (idx_last) begin
                        st <= E_IDLE;
                    end else begin
                        e_idx <= e_idx + 1'b1;
                    end
                end
                E_SUSP: begin
                    if (cmd_kind == CMD_RESUME) begin
                        st <= res_st;
                    end else if (cmd_kind == CMD_PROG && c_open && c_sec != e_sec) begin
                        p_addr    <= cmd_addr;
                        p_data    <= cmd_data;
                        cnt       <= '0;
                        retry     <= '0;
                        from_susp <= 1'b1;
                        st        <= E_PROG;
                    end
                end
                E_ERR: begin
                    if (cmd_kind == CMD_RESET) st <= E_IDLE;
                end
                default: st <= E_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fcc_status.sv
module fcc_status
    import fcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_evt,
    input  logic              rd_en,
    input  stat_t             stat,
    input  logic [FCC_DW-1:0] arr_data,
    output logic [FCC_DW-1:0] dout,
    output logic              tog_q
);

    always_ff @(posedge clk) begin
        if (rst)                     tog_q <= 1'b0;
        else if (rd_evt && stat.busy) tog_q <= ~tog_q;
    end

    always_comb begin
        if (!rd_en)         dout = '0;
        else if (stat.busy) dout = {stat.poll, tog_q, stat.err, 5'b0};
        else                dout = arr_data;
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int ARR_W       = 6,
    parameter int SEC_W       = 2,
    parameter int PROG_PULSE  = 8,
    parameter int ERASE_PULSE = 64,
    parameter int MAX_RETRY   = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ce_n,
    input  logic                   we_n,
    input  logic                   oe_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [FCC_DW-1:0]      din,
    input  logic                   vlow,
    input  logic [(1<<SEC_W)-1:0]  wp_sec,
    output logic [FCC_DW-1:0]      dout,
    output logic                   ry_by
);

    logic              we_q, oe_q;
    logic              wr_evt, rd_evt, rd_en;
    cmd_e              cmd_kind;
    eng_e              eng_st;
    stat_t             stat;
    logic [ARR_W-1:0]  eng_raddr, arr_wa;
    logic              arr_we;
    logic [FCC_DW-1:0] arr_wd, rd_host, rd_eng;
    logic              tog;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q <= 1'b1;
            oe_q <= 1'b1;
        end else begin
            we_q <= we_n;
            oe_q <= oe_n;
        end
    end

    assign wr_evt = !ce_n && we_n && !we_q && !vlow;
    assign rd_evt = !ce_n && !oe_n && oe_q;
    assign rd_en  = !ce_n && !oe_n;
    assign ry_by  = !stat.busy;

    fcc_cmd_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .wr_evt   (wr_evt),
        .wa       (addr[UNLK_AW-1:0]),
        .wd       (din),
        .cmd_kind (cmd_kind)
    );

    fcc_algo #(
        .ARR_W       (ARR_W),
        .SEC_W       (SEC_W),
        .PROG_PULSE  (PROG_PULSE),
        .ERASE_PULSE (ERASE_PULSE),
        .MAX_RETRY   (MAX_RETRY)
    ) u_algo (
        .clk       (clk),
        .rst       (rst),
        .cmd_kind  (cmd_kind),
        .cmd_addr  (addr[ARR_W-1:0]),
        .cmd_data  (din),
        .wp_sec    (wp_sec),
        .rd_word   (rd_eng),
        .st        (eng_st),
        .stat      (stat),
        .eng_raddr (eng_raddr),
        .wr_en     (arr_we),
        .wr_addr   (arr_wa),
        .wr_data   (arr_wd)
    );

    fcc_array #(.ARR_W(ARR_W)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .ra_host (addr[ARR_W-1:0]),
        .rd_host (rd_host),
        .ra_eng  (eng_raddr),
        .rd_eng  (rd_eng),
        .we      (arr_we),
        .wa      (arr_wa),
        .wd      (arr_wd)
    );

    fcc_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .rd_evt   (rd_evt),
        .rd_en    (rd_en),
        .stat     (stat),
        .arr_data (rd_host),
        .dout     (dout),
        .tog_q    (tog)
    );

endmodule

// File: rtl/fcc_checker.sv
module fcc_checker
    import fcc_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic vlow,
    input logic ry_by,
    input logic wr_evt,
    input logic rd_evt,
    input eng_e eng_st,
    input cmd_e cmd_kind,
    input logic arr_we,
    input logic tog
);

    AST_RYBY_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(ry_by) |-> $past(wr_evt));                                   // R2

    AST_TOGGLE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_evt && !ry_by) |=> (tog != $past(tog)));                       // R3

    AST_NO_WRITE_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        ry_by |-> !arr_we);                                                // R7

    AST_SUSP_IS_READY: assert property (@(posedge clk) disable iff (rst)
        (eng_st == E_SUSP) |-> ry_by);                                     // R6

    AST_VLOW_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (vlow && eng_st == E_IDLE) |=> (eng_st == E_IDLE));                // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (eng_st == E_ERR && cmd_kind != CMD_RESET) |=> (eng_st == E_ERR)); // R10

endmodule

bind flash_cmd_ctrl fcc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .vlow     (vlow),
    .ry_by    (ry_by),
    .wr_evt   (wr_evt),
    .rd_evt   (rd_evt),
    .eng_st   (eng_st),
    .cmd_kind (cmd_kind),
    .arr_we   (arr_we),
    .tog      (tog)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;

    localparam int TB_PP = 8;
    localparam int TB_EP = 20;
    localparam int TB_MR = 3;
    localparam int NW    = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0] din = '0;
    logic       vlow = 1'b0;
    logic [3:0] wp_sec = '0;
    logic [7:0] dout;
    logic       ry_by;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;
    logic [7:0] model [NW];

    always #4 clk = ~clk;

    flash_cmd_ctrl #(
        .ADDR_W(11), .ARR_W(6), .SEC_W(2),
        .PROG_PULSE(TB_PP), .ERASE_PULSE(TB_EP), .MAX_RETRY(TB_MR)
    ) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .vlow(vlow), .wp_sec(wp_sec),
        .dout(dout), .ry_by(ry_by)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); v = dout; oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic prog_seq(input logic [10:0] a, input logic [7:0] d);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(a, d);
    endtask

    task automatic erase_seq(input logic [10:0] a);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(a, 8'h30);
    endtask

    task automatic wait_ready(input int lim, output int cyc);
        cyc = 0;
        while (ry_by !== 1'b1 && cyc < lim) begin
            @(negedge clk); cyc++;
        end
        if (ry_by !== 1'b1) begin
            n_run++; n_fail++;
            $display("FAIL wait: actual ry_by %b expected 1 within %0d cycles", ry_by, lim);
        end
    endtask

    task automatic check_all(input string tag);
        logic [7:0] v;
        for (int i = 0; i < NW; i++) begin
            rd(11'(i), v);
            chk(tag, v, model[i]);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 ry_by after reset", {7'b0, ry_by}, 8'h01);
        rd(11'h000, v); chk("R1 word 0 erased", v, 8'hFF);
        rd(11'h03F, v); chk("R1 last word erased", v, 8'hFF);
    endtask

    task automatic t_program();
        logic [7:0] v; int c;
        prog_seq(11'h011, 8'hA5);
        chk("R2 busy next cycle", {7'b0, ry_by}, 8'h00);
        wait_ready(200, c);
        chk("R2 program duration", 8'(c), 8'(TB_PP));
        rd(11'h011, v); chk("R2 programmed value", v, 8'hA5);
        prog_seq(11'h011, 8'h21);
        wait_ready(200, c);
        rd(11'h011, v); chk("R2 clears bits only", v, 8'h21);
        model[17] = 8'h21;
    endtask

    task automatic t_status();
        logic [7:0] s1, s2, v; int c;
        prog_seq(11'h02A, 8'h12);
        rd(11'h000, s1);
        chk("R3 poll bit is inverted data", {7'b0, s1[7]}, 8'h01);
        chk("R3 low status bits", {3'b0, s1[5:0]}, 8'h00);
        rd(11'h000, s2);
        chk("R3 toggle inverts", {7'b0, s2[6]}, {7'b0, ~s1[6]});
        wait_ready(200, c);
        rd(11'h02A, v); chk("R3 array data after end", v, 8'h12);
        model[42] = 8'h12;
    endtask

    task automatic t_erase();
        logic [7:0] v; int c;
        prog_seq(11'h003, 8'h81); wait_ready(200, c);
        prog_seq(11'h037, 8'h0F); wait_ready(200, c);
        model[3] = 8'h81; model[55] = 8'h0F;
        erase_seq(11'h005);
        chk("R4 erase busy", {7'b0, ry_by}, 8'h00);
        rd(11'h000, v); chk("R4 poll bit 0 during erase", {7'b0, v[7]}, 8'h00);
        wait_ready(2000, c);
        for (int i = 0; i < 16; i++) model[i] = 8'hFF;
        check_all("R4 sector erased, others kept");
    endtask

    task automatic t_protect();
        logic [7:0] v;
        wp_sec = 4'b0100;
        prog_seq(11'h021, 8'h00);
        chk("R5 protected program not busy", {7'b0, ry_by}, 8'h01);
        rd(11'h021, v); chk("R5 protected word kept", v, 8'hFF);
        erase_seq(11'h025);
        chk("R5 protected erase not busy", {7'b0, ry_by}, 8'h01);
        rd(11'h02A, v); chk("R5 protected sector kept", v, 8'h12);
        wp_sec = 4'b0000;
    endtask

    task automatic t_suspend();
        logic [7:0] v; int c;
        erase_seq(11'h018);
        repeat (20) @(negedge clk);
        chk("R6 erase running", {7'b0, ry_by}, 8'h00);
        wr(11'h000, 8'hB0);
        chk("R6 ready after suspend", {7'b0, ry_by}, 8'h01);
        rd(11'h010, v); chk("R6 word 0 pre-programmed", v, 8'h00);
        rd(11'h011, v); chk("R6 word 1 pre-programmed", v, 8'h00);
        rd(11'h01F, v); chk("R6 last word not reached", v, 8'hFF);
        prog_seq(11'h020, 8'h3C);
        chk("R7 program in suspend busy", {7'b0, ry_by}, 8'h00);
        wait_ready(200, c);
        rd(11'h020, v); chk("R7 program in suspend result", v, 8'h3C);
        model[32] = 8'h3C;
        prog_seq(11'h015, 8'h00);
        chk("R7 erasing sector program refused", {7'b0, ry_by}, 8'h01);
        rd(11'h015, v); chk("R7 erasing sector word kept", v, 8'hFF);
        wr(11'h000, 8'h30);
        chk("R6 busy after resume", {7'b0, ry_by}, 8'h00);
        wait_ready(3000, c);
        for (int i = 16; i < 32; i++) model[i] = 8'hFF;
        check_all("R6 erase finished after resume");
    endtask

    task automatic t_wrong();
        logic [7:0] v;
        wr(11'h555, 8'hAA); wr(11'h123, 8'h55); wr(11'h555, 8'hA0); wr(11'h008, 8'h12);
        chk("R8 broken sequence no op", {7'b0, ry_by}, 8'h01);
        rd(11'h008, v); chk("R8 word kept", v, 8'hFF);
    endtask

    task automatic t_vlow();
        logic [7:0] v; int c;
        vlow = 1'b1;
        prog_seq(11'h009, 8'h00);
        chk("R9 inhibited write no op", {7'b0, ry_by}, 8'h01);
        rd(11'h009, v); chk("R9 word kept", v, 8'hFF);
        vlow = 1'b0;
        prog_seq(11'h009, 8'h00);
        wait_ready(200, c);
        rd(11'h009, v); chk("R9 program after supply ok", v, 8'h00);
        model[9] = 8'h00;
    endtask

    task automatic t_error();
        logic [7:0] s1, s2, v; int c;
        prog_seq(11'h030, 8'h0F); wait_ready(200, c);
        prog_seq(11'h030, 8'h33);
        repeat (TB_PP * TB_MR + 4) @(negedge clk);
        chk("R10 stays busy", {7'b0, ry_by}, 8'h00);
        rd(11'h000, s1);
        chk("R10 poll bit inverted", {7'b0, s1[7]}, 8'h01);
        chk("R10 error bit", {7'b0, s1[5]}, 8'h01);
        rd(11'h000, s2);
        chk("R10 toggle continues", {7'b0, s2[6]}, {7'b0, ~s1[6]});
        wr(11'h000, 8'hF0);
        chk("R10 ready after reset command", {7'b0, ry_by}, 8'h01);
        rd(11'h030, v); chk("R10 word holds AND", v, 8'h03);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) model[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_program();
        t_status();
        t_erase();
        t_protect();
        t_suspend();
        t_wrong();
        t_vlow();
        t_error();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule